// File: doc/BRIEF.md
# NAND Flash Operation Sequencer

This block runs a single raw operation against NAND flash devices that share an 8-bit bus. Software loads the operation's parameters into a small set of registers while the block is idle. It then writes an operation word that picks the phases to run and starts the sequence. The block drives the command and address latch enables, the write and read strobes, and one of four active-low chip enables. It also samples the device's ready/busy line.

Six phases exist and they always run in one order: first opcode, address bytes, write data, second opcode, wait for ready, read data. A phase whose enable bit is clear is skipped. A data phase with a zero byte count is skipped, and so is an address phase with a zero cycle count. Three nibbles of a timing register set the strobe widths, counted in clocks. Bytes read from the device go into a 16-entry buffer that is read through an index port. The same buffer supplies the bytes for a write-data phase.

Top module: `nand_seq`

## Requirements
- R1: After reset, `idle` is 1, all four chip enables are high, both strobes are high, CLE and ALE are low, and the timing register holds write-low 5, read-low 7 and high time 3.
- R2: The block latches the operation word and starts the sequence on the clock edge that takes a register write with `reg_sel`=5 while the block is idle. It then runs the enabled phases in the order first opcode, address, write data, second opcode, wait, read data. If no phase qualifies, the block stays idle.
- R3: Register selects: 0 = opcodes (first in [7:0], second in [15:8]), 1 = address low word, 2 = fifth address byte in [7:0], 3 = byte count in [4:0], 4 = timing, 5 = operation word, 6 = buffer load (index in [11:8], byte in [7:0]). Operation word bits: 1 read data, 2 wait ready, 3 second opcode, 4 write data, 5 address, 6 first opcode, [8:7] device select, [11:9] address cycle count.
- R4: While the block is busy, exactly the chip enable chosen by bits [8:7] is low and it does not change. All chip enables return high when the block is idle.
- R5: Each opcode byte is driven with CLE high and the data bus enabled. WE# stays low for the write-low count and then high for the high-time count.
- R6: Address bytes are driven with ALE high, least significant byte of the low word first. The fifth byte comes from register 2, and any further byte is 0x00. Their number is operation-word bits [11:9].
- R7: Timing register bits [3:0] set the write-low count, [7:4] set the read-low count and [11:8] set the high-time count. A field of 0 acts as 1.
- R8: The wait phase ends on the first clock in which R/B# is high and at least 8 clocks have passed since the last rising edge of WE#. Strobes stay high and the bus is not driven during the wait.
- R9: A read-data phase transfers the byte-count number of bytes. For each byte, RE# is low for the read-low count and then high for the high-time count. The bus value on the last low clock goes into buffer entry n for byte n, and `buf_byte` shows entry `buf_idx`.
- R10: A write-data phase drives buffer entries 0, 1, ... for the byte-count number of bytes, with strobe timing as in R5 and both CLE and ALE low.
- R11: `idle` is 0 while an operation runs. Register writes made while the block is busy, including a new operation word, have no effect.
- R12: A byte count of 0 skips both data phases, even when they are enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| buf_idx | input | 4 | Readback buffer index |
| buf_byte | output | 8 | Buffer entry at `buf_idx` |
| idle | output | 1 | 1 when no operation runs |
| nf_ce_n | output | 4 | Active-low chip enables |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_dq_out | output | 8 | Bus data out |
| nf_dq_oe | output | 1 | Bus output enable |
| nf_dq_in | input | 8 | Bus data in |
| nf_rb | input | 1 | Ready/busy, high when ready |

## Verification
Several operations are run, each with a different set of phases. An ID-style read uses one opcode, one address byte and sixteen bytes read with the reset timing. A status-style read uses an opcode and one byte. An erase-style operation uses three address bytes, two opcodes and a wait. A program-style operation uses five address bytes, write data and a wait. Between them, these runs separate the phase ordering, the address byte source and the strobe width of each nibble. The bus is driven with a different value on every clock, so the buffer contents show exactly which clock each byte was captured on. The ready line is raised once before the settling window ends and once well after it, which tells the settling rule apart from the ready rule. Runs with no qualifying phase, a zero byte count, zero timing fields, seven address cycles and register writes made during an operation cover the skip, clamp and ignore cases.

// File: rtl/nand_seq.sv
module nand_seq #(
  parameter int BUF_DEPTH = 16,
  parameter int CNT_W = 5,
  parameter int SETTLE = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic reg_we,
  input  logic [2:0] reg_sel,
  input  logic [31:0] reg_wdata,
  input  logic [$clog2(BUF_DEPTH)-1:0] buf_idx,
  output logic [7:0] buf_byte,
  output logic idle,
  output logic [3:0] nf_ce_n,
  output logic nf_cle,
  output logic nf_ale,
  output logic nf_we_n,
  output logic nf_re_n,
  output logic [7:0] nf_dq_out,
  output logic nf_dq_oe,
  input  logic [7:0] nf_dq_in,
  input  logic nf_rb
);
  localparam int IDX_W = $clog2(BUF_DEPTH);
  localparam int SET_W = $clog2(SETTLE + 1);

  typedef enum logic [2:0] {
    S_IDLE = 3'd0, S_CMD1 = 3'd1, S_ADDR = 3'd2, S_WDAT = 3'd3,
    S_CMD2 = 3'd4, S_WAIT = 3'd5, S_RDAT = 3'd6
  } st_t;

  function automatic logic ph_on(st_t s, logic [11:1] op, logic [CNT_W-1:0] n);
    case (s)
      S_CMD1:  return op[6];
      S_ADDR:  return op[5] && (op[11:9] != 3'd0);
      S_WDAT:  return op[4] && (n != '0);
      S_CMD2:  return op[3];
      S_WAIT:  return op[2];
      S_RDAT:  return op[1] && (n != '0);
      default: return 1'b0;
    endcase
  endfunction

  function automatic st_t after(st_t cur, logic [11:1] op, logic [CNT_W-1:0] n);
    st_t r = S_IDLE;
    for (int k = 6; k >= 1; k--)
      if (k > int'(cur) && ph_on(st_t'(3'(k)), op, n)) r = st_t'(3'(k));
    return r;
  endfunction

  st_t st, go_to;
  logic [11:1] op_r;
  logic [15:0] cmd_r;
  logic [31:0] alo;
  logic [7:0] ahi;
  logic [CNT_W-1:0] cnt_r, bidx, nbytes;
  logic [11:0] tim_r;
  logic [7:0] mem [BUF_DEPTH];
  logic low_ph, go;
  logic [3:0] tcnt;
  logic [SET_W-1:0] since;
  logic [7:0] abyte;

  wire accept = reg_we && (st == S_IDLE);
  wire wr_ph = (st == S_CMD1) || (st == S_ADDR) || (st == S_WDAT) || (st == S_CMD2);
  wire strobe_ph = wr_ph || (st == S_RDAT);
  wire [3:0] wl = (tim_r[3:0] == 4'd0) ? 4'd1 : tim_r[3:0];
  wire [3:0] rl = (tim_r[7:4] == 4'd0) ? 4'd1 : tim_r[7:4];
  wire [3:0] hc = (tim_r[11:8] == 4'd0) ? 4'd1 : tim_r[11:8];
  wire low_end = strobe_ph && low_ph && (tcnt == 4'd0);
  wire byte_end = strobe_ph && !low_ph && (tcnt == 4'd0);
  wire last = (bidx == nbytes - CNT_W'(1));

  assign nbytes = (st == S_ADDR) ? CNT_W'(op_r[11:9]) :
                  ((st == S_WDAT) || (st == S_RDAT)) ? cnt_r : CNT_W'(1);

  always_comb begin
    go = 1'b0;
    go_to = after(st, op_r, cnt_r);
    case (st)
      S_IDLE: begin
        go = accept && (reg_sel == 3'd5);
        go_to = after(S_IDLE, reg_wdata[11:1], cnt_r);
      end
      S_WAIT: go = (since == SET_W'(SETTLE)) && nf_rb;
      default: go = byte_end && last;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      op_r <= '0;
      cmd_r <= '0;
      alo <= '0;
      ahi <= '0;
      cnt_r <= '0;
      tim_r <= 12'h375;
      low_ph <= 1'b0;
      tcnt <= '0;
      bidx <= '0;
      since <= SET_W'(SETTLE);
      for (int i = 0; i < BUF_DEPTH; i++) mem[i] <= '0;
    end else begin
      if (accept)
        case (reg_sel)
          3'd0: cmd_r <= reg_wdata[15:0];
          3'd1: alo <= reg_wdata;
          3'd2: ahi <= reg_wdata[7:0];
          3'd3: cnt_r <= reg_wdata[CNT_W-1:0];
          3'd4: tim_r <= reg_wdata[11:0];
          3'd5: op_r <= reg_wdata[11:1];
          3'd6: mem[reg_wdata[8 +: IDX_W]] <= reg_wdata[7:0];
          default: ;
        endcase
      if (low_end && wr_ph) since <= '0;
      else if (since != SET_W'(SETTLE)) since <= since + SET_W'(1);
      if (low_end && (st == S_RDAT)) mem[bidx[IDX_W-1:0]] <= nf_dq_in;
      if (go) begin
        st <= go_to;
        bidx <= '0;
        low_ph <= 1'b1;
        tcnt <= ((go_to == S_RDAT) ? rl : wl) - 4'd1;
      end else if (low_end) begin
        low_ph <= 1'b0;
        tcnt <= hc - 4'd1;
      end else if (byte_end) begin
        bidx <= bidx + CNT_W'(1);
        low_ph <= 1'b1;
        tcnt <= ((st == S_RDAT) ? rl : wl) - 4'd1;
      end else if (tcnt != 4'd0) begin
        tcnt <= tcnt - 4'd1;
      end
    end
  end

  always_comb
    case (bidx)
      CNT_W'(0): abyte = alo[7:0];
      CNT_W'(1): abyte = alo[15:8];
      CNT_W'(2): abyte = alo[23:16];
      CNT_W'(3): abyte = alo[31:24];
      CNT_W'(4): abyte = ahi;
      default:   abyte = 8'h00;
    endcase

  always_comb
    case (st)
      S_CMD1:  nf_dq_out = cmd_r[7:0];
      S_CMD2:  nf_dq_out = cmd_r[15:8];
      S_ADDR:  nf_dq_out = abyte;
      S_WDAT:  nf_dq_out = mem[bidx[IDX_W-1:0]];
      default: nf_dq_out = 8'h00;
    endcase

  assign idle = (st == S_IDLE);
  assign nf_ce_n = idle ? 4'hF : ~(4'b0001 << op_r[8:7]);
  assign nf_cle = (st == S_CMD1) || (st == S_CMD2);
  assign nf_ale = (st == S_ADDR);
  assign nf_we_n = !(wr_ph && low_ph);
  assign nf_re_n = !((st == S_RDAT) && low_ph);
  assign nf_dq_oe = wr_ph;
  assign buf_byte = mem[buf_idx];
endmodule

// File: rtl/nand_seq_chk.sv
module nand_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic idle,
  input logic [3:0] ce_n,
  input logic cle,
  input logic ale,
  input logic we_n,
  input logic re_n,
  input logic oe
);
  a_r4_one_ce: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~ce_n) <= 1);
  a_r4_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (ce_n == 4'hF));
  a_r4_ce_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && !$past(idle)) |-> $stable(ce_n));
  a_r5_latch_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale));
  a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !re_n));
  a_r10_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    !re_n |-> !oe);
endmodule

bind nand_seq nand_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .idle(idle), .ce_n(nf_ce_n), .cle(nf_cle),
  .ale(nf_ale), .we_n(nf_we_n), .re_n(nf_re_n), .oe(nf_dq_oe)
);

// File: tb/nand_seq_tb_top.sv
module nand_seq_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, reg_we, idle, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe, nf_rb;
  logic [2:0] reg_sel;
  logic [31:0] reg_wdata;
  logic [3:0] buf_idx, nf_ce_n;
  logic [7:0] buf_byte, nf_dq_out, nf_dq_in;

  nand_seq dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .buf_idx(buf_idx), .buf_byte(buf_byte), .idle(idle), .nf_ce_n(nf_ce_n),
    .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n), .nf_re_n(nf_re_n),
    .nf_dq_out(nf_dq_out), .nf_dq_oe(nf_dq_oe), .nf_dq_in(nf_dq_in), .nf_rb(nf_rb)
  );

  int checks = 0, errors = 0;
  logic [15:0] s_cmd = 16'h0;
  logic [31:0] s_alo = 32'h0;
  logic [7:0] s_ahi = 8'h0;
  int s_cnt = 0;
  logic [11:0] s_tim = 12'h375;
  logic [7:0] s_buf [16];
  logic [17:0] q[$];
  logic [3:0] m_ce;
  int m_wl, m_rl, m_hc, m_lr;

  function automatic logic [7:0] pat(int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic void push(bit id, bit cle, bit ale, bit we, bit re, bit oe, logic [7:0] dq);
    q.push_back({id, m_ce, cle, ale, we, re, oe, oe ? dq : 8'h00});
  endfunction

  function automatic void wbyte(bit cle, bit ale, logic [7:0] dq);
    repeat (m_wl) push(0, cle, ale, 0, 1, 1, dq);
    m_lr = q.size();
    repeat (m_hc) push(0, cle, ale, 1, 1, 1, dq);
  endfunction

  task automatic wr(logic [2:0] sel, logic [31:0] data);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
    @(negedge clk);
    reg_we = 1'b0;
    case (sel)
      3'd0: s_cmd = data[15:0];
      3'd1: s_alo = data;
      3'd2: s_ahi = data[7:0];
      3'd3: s_cnt = int'(data[4:0]);
      3'd4: s_tim = data[11:0];
      3'd6: s_buf[data[11:8]] = data[7:0];
      default: ;
    endcase
  endtask

  task automatic run_op(logic [11:0] op, int k, string tag, bit inj);
    int ac, w0, c;
    logic [31:0] act;
    repeat (10) @(negedge clk);
    q.delete();
    m_ce = ~(4'b0001 << op[8:7]);
    m_wl = (s_tim[3:0] == 0) ? 1 : int'(s_tim[3:0]);
    m_rl = (s_tim[7:4] == 0) ? 1 : int'(s_tim[7:4]);
    m_hc = (s_tim[11:8] == 0) ? 1 : int'(s_tim[11:8]);
    m_lr = -1000;
    ac = int'(op[11:9]);
    if (op[6]) wbyte(1, 0, s_cmd[7:0]);
    if (op[5])
      for (int b = 0; b < ac; b++)
        wbyte(0, 1, (b < 4) ? s_alo[8*b +: 8] : (b == 4) ? s_ahi : 8'h00);
    if (op[4])
      for (int b = 0; b < s_cnt; b++) wbyte(0, 0, s_buf[b % 16]);
    if (op[3]) wbyte(1, 0, s_cmd[15:8]);
    if (op[2]) begin
      w0 = q.size();
      c = w0;
      if (m_lr + 8 > c) c = m_lr + 8;
      if (k > c) c = k;
      for (int j = w0; j <= c; j++) push(0, 0, 0, 1, 1, 0, 8'h00);
    end
    if (op[1])
      for (int b = 0; b < s_cnt; b++) begin
        repeat (m_rl) push(0, 0, 0, 1, 0, 0, 8'h00);
        s_buf[b % 16] = pat(q.size() - 1);
        repeat (m_hc) push(0, 0, 0, 1, 1, 0, 8'h00);
      end
    m_ce = 4'hF;
    push(1, 0, 0, 1, 1, 0, 8'h00);

    @(negedge clk);
    reg_we = 1'b1; reg_sel = 3'd5; reg_wdata = {20'h0, op}; nf_rb = (k <= 0);
    for (int i = 0; i < q.size(); i++) begin
      @(negedge clk);
      if (i == 0) reg_we = 1'b0;
      if (inj && i == 1) begin reg_we = 1'b1; reg_sel = 3'd0; reg_wdata = 32'h0000BEEF; end
      if (inj && i == 2) begin reg_sel = 3'd5; reg_wdata = 32'h00000E22; end
      if (inj && i == 3) reg_we = 1'b0;
      act = {14'h0, idle, nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe,
             nf_dq_oe ? nf_dq_out : 8'h00};
      chk($sformatf("%s cycle %0d", tag, i), act, {14'h0, q[i]});
      nf_dq_in = pat(i);
      nf_rb = (i >= k);
    end
  endtask

  task automatic rb_check(int n, string tag);
    for (int b = 0; b < n; b++) begin
      @(negedge clk);
      buf_idx = 4'(b);
      #1;
      chk($sformatf("%s entry %0d", tag, b), {24'h0, buf_byte}, {24'h0, s_buf[b]});
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 16; i++) s_buf[i] = 8'h00;
    rst_n = 1'b0; reg_we = 1'b0; reg_sel = 3'd0; reg_wdata = 32'h0;
    buf_idx = 4'd0; nf_dq_in = 8'h00; nf_rb = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {25'h0, idle, nf_ce_n, nf_we_n, nf_re_n},
        {25'h0, 1'b1, 4'hF, 1'b1, 1'b1});
    chk("R1 reset latches", {30'h0, nf_cle, nf_ale}, 32'h0);
    rst_n = 1'b1;

    // R1 R3 R5 R6 R9 R4: ID-style read, reset timing, one address byte, device 1
    wr(3'd0, 32'h00003090);
    wr(3'd1, 32'h44332211);
    wr(3'd2, 32'h00000055);
    wr(3'd3, 32'd16);
    run_op(12'h0E2 | 12'h200, 0, "R1 R3 R5 R6 R9 id read", 0);
    rb_check(16, "R9 buffer after id read");

    // R9 R4: status-style read, no address, device 2
    wr(3'd0, 32'h00000070);
    wr(3'd3, 32'd1);
    run_op(12'h142, 0, "R9 R4 status read", 0);
    rb_check(1, "R9 buffer after status read");

    // R7 R8: erase-style, custom timing, ready early so settling rules
    wr(3'd4, 32'h00000132);
    wr(3'd0, 32'h0000D060);
    wr(3'd1, 32'h00ABCDEF);
    run_op(12'h600 | 12'h180 | 12'h06C, 5, "R7 R8 erase settle", 0);
    run_op(12'h600 | 12'h180 | 12'h06C, 40, "R8 erase late ready", 0);

    // R2 R10 R6: program-style, five address bytes, write data, device 0
    wr(3'd4, 32'h00000375);
    wr(3'd0, 32'h00001080);
    wr(3'd1, 32'hA1B2C3D4);
    wr(3'd2, 32'h000000E5);
    wr(3'd6, 32'h0000005A);
    wr(3'd6, 32'h000001A5);
    wr(3'd6, 32'h0000020F);
    wr(3'd6, 32'h000003F0);
    wr(3'd3, 32'd4);
    run_op(12'hA00 | 12'h07C, 30, "R2 R10 R6 program", 0);

    // R6: seven address cycles, bytes beyond the fifth are zero
    run_op(12'hE00 | 12'h080 | 12'h020, 0, "R6 seven cycles", 0);

    // R7: zero timing fields act as one clock
    wr(3'd4, 32'h00000000);
    run_op(12'h140, 0, "R7 zero timing", 0);
    wr(3'd4, 32'h00000375);

    // R12: zero count skips both data phases
    wr(3'd3, 32'd0);
    run_op(12'h052, 0, "R12 zero count", 0);

    // R2: nothing qualifies, block stays idle
    run_op(12'h180, 0, "R2 no phase", 0);
    run_op(12'h020, 0, "R2 zero address cycles", 0);

    // R11: writes during an operation are ignored
    run_op(12'h048, 0, "R11 busy writes", 1);
    run_op(12'h040, 0, "R11 opcode kept", 0);

    // R8: wait-only operation
    run_op(12'h004, 3, "R8 wait only", 0);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule